// File: doc/BRIEF.md
# Asynchronous SRAM Host Bus Controller

This block sits between a synchronous host and an asynchronous static RAM with active-low chip enable, write enable and output enable, a 13-bit address and an 8-bit data bus. The host issues one read or one write at a time over a valid/ready handshake. The controller turns each request into a correctly timed pin sequence. Read data comes back with a one-cycle valid pulse.

All memory timing minimums are parameters in nanoseconds. They are converted to clock counts at elaboration, using a clock-period parameter and rounding up. A single down-counter times each phase. Writes are ended by the write-enable pulse. The address only changes while write enable is high, and host drive of the data bus starts only after the memory's output turn-off window following the write-enable fall. The data bus is split into an output, an output enable and an input, and the pad ring ties them together.

Top module: `sram_host_ctrl`

## Requirements
- R1: During and after reset, until a request is accepted, req_ready_o is 1, mem_e_no, mem_w_no and mem_g_no are 1 (inactive), mem_dq_oe_o is 0 and rvalid_o is 0.
- R2: A request is accepted on a clock edge where req_valid_i and req_ready_o are both 1 (req_we_i=1 means write, 0 means read). req_ready_o then stays 0 for a read for Nrd+1 cycles, and for a write for Nas+Nwz+Ndrv+Ndh+Nrec cycles.
- R3: A read holds mem_e_no=0, mem_g_no=0 and mem_w_no=1 for exactly Nrd cycles, where Nrd is the largest of the rounded read cycle, address access and output-enable access times. mem_w_no is never 0 while mem_g_no is 0.
- R4: Read data is captured from mem_dq_i on the edge that ends the last access cycle. It appears on rdata_o together with rvalid_o=1 for exactly one cycle, the (Nrd+1)th cycle after acceptance.
- R5: Write order: address setup with W high (Nas cycles), then W low with host drive off (Nwz cycles covering the memory turn-off time), then W low with data driven (Ndrv cycles meeting data setup, pulse width and address-to-W-rise), then W high with data still driven (Ndh cycles), then recovery with drive off (Nrec cycles).
- R6: mem_addr_o changes only on a cycle boundary where mem_w_no was 1 and mem_e_no was 1 in the cycle before.
- R7: mem_dq_oe_o is 0 in every cycle where mem_g_no is 0.
- R8: After every read there is at least one cycle with mem_e_no=1 and mem_g_no=1 before the next access, and this is the cycle in which rvalid_o is 1.
- R9: Any time parameter that rounds to zero clocks still gives a phase of one cycle. With all times 0, a read busies the block for 2 cycles and a write for 5.
- R10: A whole write, from acceptance to recovery end, lasts at least the write cycle time rounded up to clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Controller idle, request can be taken |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Request address |
| req_wdata_i | input | DATA_W | Write data |
| rvalid_o | output | 1 | Read data valid, one-cycle pulse |
| rdata_o | output | DATA_W | Captured read data |
| mem_e_no | output | 1 | Memory chip enable, active low |
| mem_w_no | output | 1 | Memory write enable, active low |
| mem_g_no | output | 1 | Memory output enable, active low |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_dq_o | output | DATA_W | Data toward memory |
| mem_dq_oe_o | output | 1 | Host drive enable of the data bus |
| mem_dq_i | input | DATA_W | Data from memory |

## Verification
The assertions assume the host keeps req_valid_i and its payload only as a request qualifier: a request is taken on a single ready edge, and the payload may change after that edge without effect. The stimulus drives requests only at falling clock edges while req_ready_o is 1 and drops req_valid_i right after acceptance. The behavioural memory in the bench answers reads only after the access times have elapsed, and returns inverted data otherwise. This means any early sample shows up as a data mismatch, while its edge-time checks catch violations of write pulse width, setup and turn-off time.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_RD_TA,
    ST_WR_AS,
    ST_WR_WZ,
    ST_WR_DRV,
    ST_WR_DH,
    ST_WR_REC
  } seq_st_e;

  // round ns up to whole clocks, never below one clock
  function automatic int ns_to_cyc(input int t_ns, input int per_ns);
    int c;
    c = (t_ns + per_ns - 1) / per_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_cyc_timer.sv
module sram_cyc_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  output logic             done_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (ld_i)           cnt_q <= ld_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/sram_seq.sv
module sram_seq
  import sram_ctrl_pkg::*;
#(
  parameter int N_RD  = 4,
  parameter int N_AS  = 1,
  parameter int N_WZ  = 2,
  parameter int N_DRV = 2,
  parameter int N_DH  = 1,
  parameter int N_REC = 1,
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_we_i,
  input  logic             tmr_done_i,
  output seq_st_e          st_d_o,
  output logic             idle_o,
  output logic             ld_o,
  output logic [CNT_W-1:0] ld_val_o,
  output logic             accept_o,
  output logic             capture_o
);

  seq_st_e st_q, st_d;

  always_comb begin
    st_d      = st_q;
    ld_o      = 1'b0;
    ld_val_o  = '0;
    accept_o  = 1'b0;
    capture_o = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid_i) begin
          accept_o = 1'b1;
          ld_o     = 1'b1;
          if (req_we_i) begin
            st_d     = ST_WR_AS;
            ld_val_o = CNT_W'(N_AS - 1);
          end else begin
            st_d     = ST_RD;
            ld_val_o = CNT_W'(N_RD - 1);
          end
        end
      end
      ST_RD: begin
        if (tmr_done_i) begin
          st_d      = ST_RD_TA;
          capture_o = 1'b1;
        end
      end
      ST_RD_TA: st_d = ST_IDLE;
      ST_WR_AS: begin
        if (tmr_done_i) begin
          st_d     = ST_WR_WZ;
          ld_o     = 1'b1;
          ld_val_o = CNT_W'(N_WZ - 1);
        end
      end
      ST_WR_WZ: begin
        if (tmr_done_i) begin
          st_d     = ST_WR_DRV;
          ld_o     = 1'b1;
          ld_val_o = CNT_W'(N_DRV - 1);
        end
      end
      ST_WR_DRV: begin
        if (tmr_done_i) begin
          st_d     = ST_WR_DH;
          ld_o     = 1'b1;
          ld_val_o = CNT_W'(N_DH - 1);
        end
      end
      ST_WR_DH: begin
        if (tmr_done_i) begin
          st_d     = ST_WR_REC;
          ld_o     = 1'b1;
          ld_val_o = CNT_W'(N_REC - 1);
        end
      end
      ST_WR_REC: if (tmr_done_i) st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign st_d_o = st_d;
  assign idle_o = (st_q == ST_IDLE);

endmodule

// File: rtl/sram_pin_io.sv
module sram_pin_io
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  seq_st_e           st_d_i,
  input  logic              accept_i,
  input  logic              capture_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              mem_e_no,
  output logic              mem_w_no,
  output logic              mem_g_no,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o
);

  logic              e_n_q, w_n_q, g_n_q, oe_q, rvalid_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept_i) begin
      addr_q  <= req_addr_i;
      wdata_q <= req_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= capture_i;
      if (capture_i) rdata_q <= mem_dq_i;
    end
  end

  // pins registered from next state: glitch-free strobes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      e_n_q <= 1'b1;
      w_n_q <= 1'b1;
      g_n_q <= 1'b1;
      oe_q  <= 1'b0;
    end else begin
      e_n_q <= (st_d_i == ST_IDLE) || (st_d_i == ST_RD_TA);
      w_n_q <= !((st_d_i == ST_WR_WZ) || (st_d_i == ST_WR_DRV));
      g_n_q <= (st_d_i != ST_RD);
      oe_q  <= (st_d_i == ST_WR_DRV) || (st_d_i == ST_WR_DH);
    end
  end

  assign rvalid_o    = rvalid_q;
  assign rdata_o     = rdata_q;
  assign mem_e_no    = e_n_q;
  assign mem_w_no    = w_n_q;
  assign mem_g_no    = g_n_q;
  assign mem_addr_o  = addr_q;
  assign mem_dq_o    = wdata_q;
  assign mem_dq_oe_o = oe_q;

endmodule

// File: rtl/sram_host_ctrl.sv
module sram_host_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W        = 13,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 8,
  parameter int T_RC_NS       = 25,
  parameter int T_AA_NS       = 25,
  parameter int T_OE_NS       = 10,
  parameter int T_WC_NS       = 25,
  parameter int T_WP_NS       = 20,
  parameter int T_DS_NS       = 10,
  parameter int T_DH_NS       = 0,
  parameter int T_AS_NS       = 0,
  parameter int T_AW_NS       = 20,
  parameter int T_WZ_NS       = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              mem_e_no,
  output logic              mem_w_no,
  output logic              mem_g_no,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [DATA_W-1:0] mem_dq_i
);

  localparam int N_RD  = imax(imax(ns_to_cyc(T_RC_NS, CLK_PERIOD_NS),
                                   ns_to_cyc(T_AA_NS, CLK_PERIOD_NS)),
                              ns_to_cyc(T_OE_NS, CLK_PERIOD_NS));
  localparam int N_AS  = ns_to_cyc(T_AS_NS, CLK_PERIOD_NS);
  localparam int N_WZ  = ns_to_cyc(T_WZ_NS, CLK_PERIOD_NS);
  localparam int N_DRV = imax(imax(ns_to_cyc(T_DS_NS, CLK_PERIOD_NS),
                                   ns_to_cyc(T_WP_NS, CLK_PERIOD_NS) - N_WZ),
                              imax(ns_to_cyc(T_AW_NS, CLK_PERIOD_NS) - N_AS - N_WZ, 1));
  localparam int N_DH  = ns_to_cyc(T_DH_NS, CLK_PERIOD_NS);
  localparam int N_REC = imax(ns_to_cyc(T_WC_NS, CLK_PERIOD_NS) - N_AS - N_WZ - N_DRV - N_DH, 1);
  localparam int N_MAX = imax(imax(imax(N_RD, N_AS), imax(N_WZ, N_DRV)), imax(N_DH, N_REC));
  localparam int CNT_W = $clog2(N_MAX + 1);

  seq_st_e          st_d;
  logic             tmr_ld, tmr_done, accept, capture;
  logic [CNT_W-1:0] tmr_val;

  sram_cyc_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ld_i     (tmr_ld),
    .ld_val_i (tmr_val),
    .done_o   (tmr_done)
  );

  sram_seq #(
    .N_RD(N_RD), .N_AS(N_AS), .N_WZ(N_WZ), .N_DRV(N_DRV),
    .N_DH(N_DH), .N_REC(N_REC), .CNT_W(CNT_W)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_we_i    (req_we_i),
    .tmr_done_i  (tmr_done),
    .st_d_o      (st_d),
    .idle_o      (req_ready_o),
    .ld_o        (tmr_ld),
    .ld_val_o    (tmr_val),
    .accept_o    (accept),
    .capture_o   (capture)
  );

  sram_pin_io #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_io (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .st_d_i      (st_d),
    .accept_i    (accept),
    .capture_i   (capture),
    .req_addr_i  (req_addr_i),
    .req_wdata_i (req_wdata_i),
    .mem_dq_i    (mem_dq_i),
    .rvalid_o    (rvalid_o),
    .rdata_o     (rdata_o),
    .mem_e_no    (mem_e_no),
    .mem_w_no    (mem_w_no),
    .mem_g_no    (mem_g_no),
    .mem_addr_o  (mem_addr_o),
    .mem_dq_o    (mem_dq_o),
    .mem_dq_oe_o (mem_dq_oe_o)
  );

endmodule

// File: rtl/sram_host_ctrl_chk.sv
module sram_host_ctrl_chk #(
  parameter int ADDR_W = 13
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              rvalid_o,
  input logic              mem_e_no,
  input logic              mem_w_no,
  input logic              mem_g_no,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_dq_oe_o
);

  assert_busy_after_accept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

  assert_w_high_in_read_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_g_no |-> mem_w_no);

  assert_rvalid_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o);

  assert_no_drive_at_wfall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_w_no) |-> !mem_dq_oe_o);

  assert_addr_hold_w_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_w_no && $past(!mem_w_no)) |-> $stable(mem_addr_o));

  assert_addr_hold_e_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_e_no && $past(!mem_e_no)) |-> $stable(mem_addr_o));

  assert_no_drive_g_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_g_no |-> !mem_dq_oe_o);

  assert_turnaround_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_g_no) |-> (mem_e_no && rvalid_o));

endmodule

bind sram_host_ctrl sram_host_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .rvalid_o    (rvalid_o),
  .mem_e_no    (mem_e_no),
  .mem_w_no    (mem_w_no),
  .mem_g_no    (mem_g_no),
  .mem_addr_o  (mem_addr_o),
  .mem_dq_oe_o (mem_dq_oe_o)
);

// File: tb/tb_sram_host_ctrl.sv
`timescale 1ns/1ps
module tb_sram_host_ctrl;

  localparam int PER = 8;
  function automatic int cy(input int ns);
    int c;
    c = (ns + PER - 1) / PER;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // expected phase lengths for the default timing set
  localparam int E_RD  = mx(mx(cy(25), cy(25)), cy(10));
  localparam int E_AS  = cy(0);
  localparam int E_WZ  = cy(10);
  localparam int E_DRV = mx(mx(cy(10), cy(20) - E_WZ), mx(cy(20) - E_AS - E_WZ, 1));
  localparam int E_DH  = cy(0);
  localparam int E_REC = mx(cy(25) - E_AS - E_WZ - E_DRV - E_DH, 1);
  localparam int E_WR  = E_AS + E_WZ + E_DRV + E_DH + E_REC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  int total = 0;
  int bad = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input real act, input real exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0.2f expected=%0.2f", req, what, act, exp);
    end
  endtask

  // main DUT, small address space
  logic       valid = 1'b0, we = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic       ready, rvalid, e_n, w_n, g_n, dq_oe;
  logic [7:0] rdata, maddr, dq_o, dq_i;

  sram_host_ctrl #(.ADDR_W(8), .DATA_W(8), .CLK_PERIOD_NS(PER)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_ready_o(ready),
    .req_we_i(we), .req_addr_i(addr), .req_wdata_i(wdata),
    .rvalid_o(rvalid), .rdata_o(rdata), .mem_e_no(e_n), .mem_w_no(w_n),
    .mem_g_no(g_n), .mem_addr_o(maddr), .mem_dq_o(dq_o),
    .mem_dq_oe_o(dq_oe), .mem_dq_i(dq_i)
  );

  // behavioural asynchronous RAM with edge timing checks
  logic [7:0] mem [256];
  real t_addr = 0.0, t_ef = 0.0, t_gf = 0.0, t_wf = 0.0, t_drv = 0.0;
  bit  acc_ok = 1'b0;
  bit  w_low_seen = 1'b0;

  initial for (int i = 0; i < 256; i++) mem[i] = 8'h00;

  initial forever begin
    #0.5;
    acc_ok = ($realtime - t_addr >= 25.0) && ($realtime - t_ef >= 25.0) &&
             ($realtime - t_gf >= 10.0);
  end

  assign dq_i = (!e_n && !g_n && w_n && acc_ok) ? mem[maddr] : ~mem[maddr];

  always @(maddr) begin
    if (rst_n) chk(!(!e_n && !w_n), "R6", "address moved with E and W low", 0.0, 1.0);
    t_addr = $realtime;
  end
  always @(negedge e_n) t_ef = $realtime;
  always @(negedge g_n) t_gf = $realtime;

  always @(negedge w_n) if (rst_n) begin
    w_low_seen = 1'b1;
    t_wf = $realtime;
    chk(!dq_oe, "R5", "host drive at W fall", real'(dq_oe), 0.0);
    chk(g_n, "R3", "G low at W fall", real'(g_n), 1.0);
  end

  always @(posedge w_n) if (w_low_seen) begin
    w_low_seen = 1'b0;
    chk($realtime - t_wf >= 20.0, "R5", "W pulse ns", $realtime - t_wf, 20.0);
    chk(dq_oe, "R5", "data driven at W rise", real'(dq_oe), 1.0);
    chk($realtime - t_drv >= 10.0, "R5", "data setup ns", $realtime - t_drv, 10.0);
    chk($realtime - t_addr >= 20.0, "R5", "address to W rise ns", $realtime - t_addr, 20.0);
    if (dq_oe && !e_n) mem[maddr] = dq_o;
  end

  always @(posedge dq_oe) begin
    t_drv = $realtime;
    chk(g_n, "R7", "drive while G low", real'(g_n), 1.0);
    if (!w_n) chk($realtime - t_wf >= 10.0, "R5", "drive after W fall ns",
                  $realtime - t_wf, 10.0);
  end

  always @(negedge dq_oe) if (rst_n)
    chk(w_n, "R5", "drive released while W low", real'(w_n), 1.0);

  // second DUT with zero timings
  logic       v2 = 1'b0, we2 = 1'b0;
  logic [3:0] a2 = '0;
  logic       rdy2, rv2, e2, w2, g2, oe2;
  logic [7:0] rd2, dqo2, dqi2;
  logic [3:0] ma2;

  sram_host_ctrl #(.ADDR_W(4), .DATA_W(8), .CLK_PERIOD_NS(PER),
    .T_RC_NS(0), .T_AA_NS(0), .T_OE_NS(0), .T_WC_NS(0), .T_WP_NS(0),
    .T_DS_NS(0), .T_DH_NS(0), .T_AS_NS(0), .T_AW_NS(0), .T_WZ_NS(0)) dut_z (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(v2), .req_ready_o(rdy2),
    .req_we_i(we2), .req_addr_i(a2), .req_wdata_i(8'h66),
    .rvalid_o(rv2), .rdata_o(rd2), .mem_e_no(e2), .mem_w_no(w2),
    .mem_g_no(g2), .mem_addr_o(ma2), .mem_dq_o(dqo2),
    .mem_dq_oe_o(oe2), .mem_dq_i(dqi2)
  );
  assign dqi2 = {4'hA, ma2};

  logic [7:0] shadow [256];

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) ^ (a >> 3));
  endfunction

  // called at a falling edge; returns at the falling edge where ready is back
  task automatic do_write(input logic [7:0] a, input logic [7:0] d);
    int busy, wl, oc;
    while (!ready) @(negedge clk);
    valid = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    valid = 1'b0; addr = ~a; wdata = ~d;
    busy = 0; wl = 0; oc = 0;
    while (!ready) begin
      busy++;
      if (!w_n) wl++;
      if (dq_oe) oc++;
      @(negedge clk);
    end
    shadow[a] = d;
    chk(busy == E_WR, "R2", "write busy cycles", busy, E_WR);
    chk(busy >= cy(25), "R10", "write cycle clocks", busy, cy(25));
    chk(wl == E_WZ + E_DRV, "R5", "W low cycles", wl, E_WZ + E_DRV);
    chk(oc == E_DRV + E_DH, "R5", "drive cycles", oc, E_DRV + E_DH);
  endtask

  task automatic do_read(input logic [7:0] a);
    int busy, gl, rv, rv_at;
    logic [7:0] got;
    while (!ready) @(negedge clk);
    valid = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    valid = 1'b0; addr = ~a;
    busy = 0; gl = 0; rv = 0; rv_at = 0; got = '0;
    while (!ready) begin
      busy++;
      if (!g_n) gl++;
      if (rvalid) begin
        rv++; rv_at = busy; got = rdata;
        chk(e_n && g_n, "R8", "turnaround idle pins", real'(e_n && g_n), 1.0);
      end
      @(negedge clk);
    end
    chk(busy == E_RD + 1, "R2", "read busy cycles", busy, E_RD + 1);
    chk(gl == E_RD, "R3", "G low cycles", gl, E_RD);
    chk(rv == 1 && rv_at == E_RD + 1, "R4", "rvalid position", rv_at, E_RD + 1);
    chk(got == shadow[a], "R4", "read data", got, shadow[a]);
  endtask

  initial begin
    #(PER * 200000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=expired expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int x;
    for (int i = 0; i < 256; i++) shadow[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk(ready && e_n && w_n && g_n && !dq_oe && !rvalid, "R1", "pins in reset",
        real'({ready, e_n, w_n, g_n, dq_oe, rvalid}), real'(6'b111100));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(ready && e_n && w_n && g_n && !dq_oe && !rvalid, "R1", "idle after reset",
        real'({ready, e_n, w_n, g_n, dq_oe, rvalid}), real'(6'b111100));

    for (int a = 0; a < 256; a++) do_write(8'(a), pat(a));
    for (int a = 255; a >= 0; a--) do_read(8'(a));

    // mixed traffic, back to back, read followed directly by write
    x = 17;
    for (int k = 0; k < 200; k++) begin
      x = (x * 5 + 3) % 256;
      if (k % 3 == 1) do_write(8'(x), 8'(x ^ k));
      else            do_read(8'(x));
    end

    // R9: all-zero timings give one-cycle phases
    begin
      int busy, wl;
      logic [7:0] got;
      v2 = 1'b1; we2 = 1'b1; a2 = 4'h5;
      @(negedge clk);
      v2 = 1'b0;
      busy = 0; wl = 0;
      while (!rdy2) begin busy++; if (!w2) wl++; @(negedge clk); end
      chk(busy == 5, "R9", "zero-time write cycles", busy, 5);
      chk(wl == 2, "R9", "zero-time W low cycles", wl, 2);
      v2 = 1'b1; we2 = 1'b0; a2 = 4'h9;
      @(negedge clk);
      v2 = 1'b0;
      busy = 0; got = '0;
      while (!rdy2) begin busy++; if (rv2) got = rd2; @(negedge clk); end
      chk(busy == 2, "R9", "zero-time read cycles", busy, 2);
      chk(got == 8'hA9, "R9", "zero-time read data", got, 8'hA9);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule